// File: doc/BRIEF.md
# Keyed DDS Sine Source

This block is a numerically controlled oscillator for a 12-bit DAC. A 19-bit phase register advances by a frequency word on every clock. Its ten upper bits index a sine table, and the table produces one amplitude code per clock. At a 52.4288 MHz clock, one count of the frequency word is a 100 Hz step. Words from 10 to 100000 cover the range from 1 kHz to 10 MHz.

The same oscillator also carries two binary keying schemes, both driven by a serial data bit:
- **On/off keying:** the data bit gates the sample to the zero code.
- **Phase keying:** the data bit moves the table lookup by half a cycle.

A small mode machine has three states, `ST_CARRIER`, `ST_ASK` and `ST_PSK`. It selects the scheme. Its only transitions happen on a load strobe, where it moves to the state named by the mode input. The reserved code 3 leads to `ST_CARRIER`. Reset puts the machine in `ST_CARRIER`.

A new word and mode are captured together and used from the following clock onward. The phase register is never cleared by a load, so the phase stays continuous across frequency changes.

Top module: `dds_keyed_source`

## Requirements
- R1: The phase register adds the active frequency word on every clock, modulo 2^19. Loading a new word never resets it, so the phase stays continuous.
- R2: The table entry at index a (0..1023) is floor(2048.5 + 2047·sin(2πa/1024)). This is offset binary, with 2048 as the zero-amplitude code.
- R3: The output register is loaded on each clock from the phase, mode and held bit as they stood before that clock. The table index is phase bits [18:9].
- R4: On a clock with freq_load high, freq_word and mode_sel are captured, and the phase uses the new word from the next clock. With freq_load low, both inputs have no effect.
- R5: mode_sel encoding: 0 = plain carrier, 1 = on/off keying, 2 = phase keying, 3 = plain carrier.
- R6: In on/off keying, a held bit of 1 passes the table sample and a held bit of 0 gives 2048.
- R7: In phase keying, a held bit of 1 inverts bit 9 of the table index, which adds 512 entries (180 degrees). A held bit of 0 leaves the index unchanged.
- R8: key_bit is captured only on a clock with key_stb high and is held until the next strobe.
- R9: Synchronous active-high reset clears the phase, the frequency word and the held bit. It selects the carrier mode and sets the output to 2048.
- R10: A load and a bit strobe in the same clock both take effect, and the next sample uses neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 19 | Frequency word, captured on freq_load |
| freq_load | input | 1 | Capture strobe for freq_word and mode_sel |
| mode_sel | input | 2 | Keying mode, captured on freq_load |
| key_bit | input | 1 | Serial baseband data bit |
| key_stb | input | 1 | Capture strobe for key_bit |
| sample | output | 12 | Amplitude code for the DAC |

## Verification
Two functions can land in the same clock: a word or mode load, and a data-bit capture. Both can also coincide with the phase register wrapping past 2^19. Every stimulus vector raises freq_load and key_stb together, including a near-full-scale word that wraps almost every clock. The sample after that edge and every following sample are compared with a bench model built from the timing rules. The model requires the old word, mode and bit for one more sample, and the new ones from the sample after.

// File: rtl/dds_pkg.sv
package dds_pkg;
    typedef enum logic [1:0] {
        ST_CARRIER = 2'd0,
        ST_ASK     = 2'd1,
        ST_PSK     = 2'd2
    } key_state_t;

    localparam logic [1:0] SEL_CARRIER  = 2'd0;
    localparam logic [1:0] SEL_ASK      = 2'd1;
    localparam logic [1:0] SEL_PSK      = 2'd2;
    localparam logic [1:0] SEL_RESERVED = 2'd3;
endpackage

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
    parameter int ACC_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] freq_word,
    input  logic             freq_load,
    output logic [ACC_W-1:0] phase
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] step_q;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            step_q <= '0;
            armed  <= 1'b0;
        end else begin
            acc_q <= acc_q + step_q;
            if (freq_load) begin
                step_q <= freq_word;
            end
            armed <= 1'b1;
        end
    end

    assign phase = acc_q;

    // R1: phase advances by the word that was active one clock earlier
    assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
        armed |=> acc_q == ACC_W'($past(acc_q) + $past(step_q)));

    // R4: capture on load, hold otherwise
    assert_word_load_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && freq_load) |=> step_q == $past(freq_word));
    assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && !freq_load) |=> $stable(step_q));
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 12,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int  DEPTH = 1 << ADDR_W;
    localparam int  MID   = 1 << (DATA_W - 1);
    localparam int  AMP   = MID - 1;
    localparam real TWO_PI = 6.283185307179586;

    logic [DATA_W-1:0] tab [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam real PHI = TWO_PI * i / DEPTH;
        localparam int  RAW = $rtoi(MID + 0.5 + AMP * $sin(PHI));
        if (SIGNED_OUT) begin : g_twos
            assign tab[i] = DATA_W'(RAW) ^ DATA_W'(MID);
        end else begin : g_offset
            assign tab[i] = DATA_W'(RAW);
        end
    end

    assign data = tab[addr];
endmodule

// File: rtl/dds_key_ctrl.sv
module dds_key_ctrl
    import dds_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 12,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freq_load,
    input  logic [1:0]        mode_sel,
    input  logic              key_bit,
    input  logic              key_stb,
    input  logic [ADDR_W-1:0] phase_top,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_data,
    output logic [DATA_W-1:0] sample
);
    localparam logic [DATA_W-1:0] ZERO_CODE =
        SIGNED_OUT ? '0 : DATA_W'(1 << (DATA_W - 1));
    localparam logic [ADDR_W-1:0] HALF_TURN = ADDR_W'(1 << (ADDR_W - 1));

    key_state_t        state, state_nx;
    logic              bit_q;
    logic [DATA_W-1:0] sample_q, sample_nx;
    logic              armed;

    // next mode, only on a load
    always_comb begin
        state_nx = state;
        if (freq_load) begin
            unique case (mode_sel)
                SEL_CARRIER:  state_nx = ST_CARRIER;
                SEL_ASK:      state_nx = ST_ASK;
                SEL_PSK:      state_nx = ST_PSK;
                SEL_RESERVED: state_nx = ST_CARRIER;
                default:      state_nx = ST_CARRIER;
            endcase
        end
    end

    // state register and held data bit
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CARRIER;
            bit_q <= 1'b0;
            armed <= 1'b0;
        end else begin
            state <= state_nx;
            if (key_stb) begin
                bit_q <= key_bit;
            end
            armed <= 1'b1;
        end
    end

    // outputs: table index and gated sample
    always_comb begin
        rom_addr  = phase_top;
        sample_nx = rom_data;
        unique case (state)
            ST_CARRIER: begin
                rom_addr  = phase_top;
                sample_nx = rom_data;
            end
            ST_ASK: begin
                rom_addr  = phase_top;
                sample_nx = bit_q ? rom_data : ZERO_CODE;
            end
            ST_PSK: begin
                rom_addr  = bit_q ? (phase_top ^ HALF_TURN) : phase_top;
                sample_nx = rom_data;
            end
            default: begin
                rom_addr  = phase_top;
                sample_nx = rom_data;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= ZERO_CODE;
        end else begin
            sample_q <= sample_nx;
        end
    end

    assign sample = sample_q;

    assert_bit_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (armed && !key_stb) |=> $stable(bit_q));

    assert_bit_take_R8: assert property (@(posedge clk) disable iff (rst)
        (armed && key_stb) |=> bit_q == $past(key_bit));

    assert_ask_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (armed && state == ST_ASK && !bit_q) |=> sample_q == ZERO_CODE);

    assert_reserved_mode_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && freq_load && mode_sel == SEL_RESERVED) |=> state == ST_CARRIER);

    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && !freq_load) |=> $stable(state));

    assert_reset_out_R9: assert property (@(posedge clk)
        rst |=> (sample_q == ZERO_CODE && bit_q == 1'b0 && state == ST_CARRIER));
endmodule

// File: rtl/dds_keyed_source.sv
module dds_keyed_source #(
    parameter int ACC_W      = 19,
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 12,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  freq_word,
    input  logic              freq_load,
    input  logic [1:0]        mode_sel,
    input  logic              key_bit,
    input  logic              key_stb,
    output logic [DATA_W-1:0] sample
);
    logic [ACC_W-1:0]  phase;
    logic [ADDR_W-1:0] rom_addr;
    logic [DATA_W-1:0] rom_data;

    dds_phase_accum #(.ACC_W(ACC_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .freq_word (freq_word),
        .freq_load (freq_load),
        .phase     (phase)
    );

    dds_key_ctrl #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SIGNED_OUT (SIGNED_OUT)
    ) u_key (
        .clk       (clk),
        .rst       (rst),
        .freq_load (freq_load),
        .mode_sel  (mode_sel),
        .key_bit   (key_bit),
        .key_stb   (key_stb),
        .phase_top (phase[ACC_W-1 -: ADDR_W]),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .sample    (sample)
    );

    dds_sine_rom #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SIGNED_OUT (SIGNED_OUT)
    ) u_rom (
        .addr (rom_addr),
        .data (rom_data)
    );
endmodule

// File: tb/tb_dds_keyed_source.sv
module tb_dds_keyed_source;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [18:0] freq_word = '0;
    logic        freq_load = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        key_bit = 1'b0;
    logic        key_stb = 1'b0;
    logic [11:0] sample;

    int errors = 0;
    int checks = 0;

    // bench model state
    logic [18:0] m_acc = '0, m_k = '0;
    logic [1:0]  m_mode = 2'd0;
    logic        m_bit = 1'b0;
    logic [11:0] m_sample = 12'd2048;

    always #10 clk = ~clk;

    dds_keyed_source dut (
        .clk(clk), .rst(rst), .freq_word(freq_word), .freq_load(freq_load),
        .mode_sel(mode_sel), .key_bit(key_bit), .key_stb(key_stb), .sample(sample)
    );

    // vector: {mode[1:0], word[18:0], bit, cycles[7:0]}
    localparam int NV = 8;
    localparam logic [29:0] VEC [NV] = '{
        {2'd0, 19'd10,     1'b0, 8'd20},
        {2'd0, 19'd100000, 1'b1, 8'd40},
        {2'd1, 19'd5000,   1'b1, 8'd30},
        {2'd1, 19'd5000,   1'b0, 8'd30},
        {2'd2, 19'd3000,   1'b0, 8'd30},
        {2'd2, 19'd3000,   1'b1, 8'd30},
        {2'd3, 19'd777,    1'b1, 8'd20},
        {2'd0, 19'd524287, 1'b0, 8'd20}
    };

    // R2: table value from the formula
    function automatic logic [11:0] tab_val(input int a);
        real phi;
        phi = 6.283185307179586 * a / 1024;
        return 12'($rtoi(2048 + 0.5 + 2047 * $sin(phi)));
    endfunction

    function automatic logic [11:0] model_out();
        int a;
        a = int'(m_acc[18:9]);
        if (m_mode == 2'd2 && m_bit) a = a ^ 512;
        if (m_mode == 2'd1 && !m_bit) return 12'd2048;
        return tab_val(a);
    endfunction

    task automatic tick(input string tag);
        @(posedge clk);
        if (rst) begin
            m_acc = '0; m_k = '0; m_bit = 1'b0; m_mode = 2'd0; m_sample = 12'd2048;
        end else begin
            m_sample = model_out();
            m_acc    = m_acc + m_k;
            if (freq_load) begin
                m_k    = freq_word;
                m_mode = (mode_sel == 2'd3) ? 2'd0 : mode_sel;
            end
            if (key_stb) m_bit = key_bit;
        end
        @(negedge clk);
        checks++;
        if (sample !== m_sample) begin
            errors++;
            $display("FAIL %s: sample=%0d expected=%0d", tag, sample, m_sample);
        end
    endtask

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'd1:    return "R6";
            2'd2:    return "R7";
            2'd3:    return "R5";
            default: return "R2";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R9: reset state
        tick("R9");
        tick("R9");
        rst = 1'b0;
        tick("R9");  // zero word: phase stays at 0, sample 2048
        tick("R3");

        // vector table: load and bit strobe together each time (R10), phase never reset (R1)
        for (int v = 0; v < NV; v++) begin
            freq_word = VEC[v][27:9];
            mode_sel  = VEC[v][29:28];
            key_bit   = VEC[v][8];
            freq_load = 1'b1;
            key_stb   = 1'b1;
            tick("R10");
            freq_load = 1'b0;
            key_stb   = 1'b0;
            tick("R10");
            for (int c = 0; c < int'(VEC[v][7:0]); c++) tick(tag_of(VEC[v][29:28]));
        end

        // R4: word and mode inputs ignored without load
        freq_word = 19'd1234;
        mode_sel  = 2'd1;
        for (int c = 0; c < 20; c++) tick("R4");

        // R8: PSK with bit changing but no strobe, then strobed
        freq_word = 19'd4096; mode_sel = 2'd2; freq_load = 1'b1;
        tick("R4");
        freq_load = 1'b0;
        for (int c = 0; c < 16; c++) begin
            key_bit = ~key_bit;
            tick("R8");
        end
        key_bit = 1'b1; key_stb = 1'b1;
        tick("R8");
        key_stb = 1'b0; key_bit = 1'b0;
        for (int c = 0; c < 10; c++) tick("R7");

        // R1: change word mid-run, phase continuous
        freq_word = 19'd70000; freq_load = 1'b1;
        tick("R1");
        freq_load = 1'b0;
        for (int c = 0; c < 20; c++) tick("R1");

        // R9: reset mid-run
        rst = 1'b1;
        tick("R9");
        rst = 1'b0;
        for (int c = 0; c < 5; c++) tick("R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule